// File: doc/BRIEF.md
# Configurable Two-Plane Sum-of-Products Array

This block is a field-configurable combinational logic array. An AND plane and an OR plane are held in configuration registers. Each product term can take the true or the complemented form of any input. Each output is a programmable OR over the product terms. Any product term may drive any number of outputs, so one term can be shared between several output functions. Any sum-of-products function fits, as long as it needs no more than the configured input, output and product-term counts.

A host loads the two planes one row at a time through a small register port. The port has a write strobe, a plane select, a row address and a data word. Each write takes effect at the next rising clock edge. Between writes, the path from the inputs to the outputs holds no registers.

Top module: `pla_array`

## Requirements
- R1: After reset every AND-plane and OR-plane row is zero, so every output is 0 for every input pattern until the first write.
- R2: In an AND-plane row, bit 2i selects the true form of input i and bit 2i+1 selects its complement. A product term is the AND of all the literals it selects.
- R3: A product term that selects no literals evaluates to 1.
- R4: A product term that selects both the true and the complemented form of the same input evaluates to 0.
- R5: Output o is the OR of every product term t whose bit t is set in OR-plane row o. One term may feed several outputs at once.
- R6: An output whose OR-plane row is all zero drives 0.
- R7: A write with cfgPlane 0 loads AND-plane row cfgRow, and a write with cfgPlane 1 loads OR-plane row cfgRow. The new row acts on the outputs only after the next rising clock edge. Before that edge the outputs still follow the old row.
- R8: A write whose row address is at or above the number of rows in the selected plane changes nothing. There are NumTerms AND rows and NumOut OR rows.
- R9: The outputs follow a change on dataIn within the same clock cycle, with no clock edge in between.
- R10: For random configurations of both planes, the outputs match a sum-of-products model for every input pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Configuration clock |
| rstN | input | 1 | Active-low synchronous reset of both planes |
| cfgWe | input | 1 | Configuration write strobe |
| cfgPlane | input | 1 | Plane select: 0 for the AND plane, 1 for the OR plane |
| cfgRow | input | AddrW | Row address within the selected plane |
| cfgData | input | DataW | Row contents. The AND plane uses the low 2*NumIn bits and the OR plane uses the low NumTerms bits |
| dataIn | input | NumIn | Logic inputs |
| dataOut | output | NumOut | Sum-of-products outputs |

## Verification
The bound checker runs on every clock. It checks that outputs are zero at reset release, and that the outputs hold whenever no write happened and the inputs did not change. It also checks that a write to a row outside the selected plane leaves the outputs unchanged, that a high output always has at least one active product term behind it, and that the control never raises both plane strobes at once. Some behaviours can only be shown by the bench's scenarios against its sum-of-products model: the literal encoding, the empty and contradictory terms, sharing one term between outputs, the old-row value just before a write's edge, and mid-cycle input changes.

// File: rtl/pla_pkg.sv
package pla_pkg;

  typedef enum logic {
    PLANE_AND = 1'b0,
    PLANE_OR  = 1'b1
  } plane_e;

  // Per-cycle write strobes from the control to the datapath
  typedef struct packed {
    logic andWrite;
    logic orWrite;
  } cfgStrobe_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pla_ctrl.sv
module pla_ctrl #(
  parameter int NumTerms = 6,
  parameter int NumOut   = 3,
  parameter int AddrW    = 3
) (
  input  logic                     cfgWe,
  input  logic                     cfgPlane,
  input  logic [AddrW-1:0]         cfgRow,
  output pla_pkg::cfgStrobe_t      strobe
);
  import pla_pkg::*;

  plane_e plane;
  logic   andRowOk;
  logic   orRowOk;

  assign plane    = plane_e'(cfgPlane);
  assign andRowOk = int'(cfgRow) < NumTerms;
  assign orRowOk  = int'(cfgRow) < NumOut;

  always_comb begin
    strobe          = '0;
    strobe.andWrite = cfgWe && (plane == PLANE_AND) && andRowOk;
    strobe.orWrite  = cfgWe && (plane == PLANE_OR)  && orRowOk;
  end

endmodule

// File: rtl/pla_datapath.sv
module pla_datapath #(
  parameter int NumIn    = 4,
  parameter int NumOut   = 3,
  parameter int NumTerms = 6,
  parameter int AddrW    = 3,
  parameter int DataW    = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  pla_pkg::cfgStrobe_t      strobe,
  input  logic [AddrW-1:0]         cfgRow,
  input  logic [DataW-1:0]         cfgData,
  input  logic [NumIn-1:0]         dataIn,
  output logic [NumTerms-1:0]      termVec,
  output logic [NumOut-1:0]        dataOut
);
  localparam int LitW = 2 * NumIn;

  logic [LitW-1:0]     literals;
  logic [LitW-1:0]     andRow [NumTerms];
  logic [NumTerms-1:0] orRow  [NumOut];

  // Literal 2i is input i, literal 2i+1 is its complement
  for (genvar i = 0; i < NumIn; i++) begin : g_lit
    assign literals[2*i]   = dataIn[i];
    assign literals[2*i+1] = ~dataIn[i];
  end

  for (genvar t = 0; t < NumTerms; t++) begin : g_and
    always_ff @(posedge clk) begin
      if (!rstN) begin
        andRow[t] <= '0;
      end else if (strobe.andWrite && (int'(cfgRow) == t)) begin
        andRow[t] <= cfgData[LitW-1:0];
      end
    end
    // Unselected literals are masked to 1; an empty row gives 1
    assign termVec[t] = &(literals | ~andRow[t]);
  end

  for (genvar o = 0; o < NumOut; o++) begin : g_or
    always_ff @(posedge clk) begin
      if (!rstN) begin
        orRow[o] <= '0;
      end else if (strobe.orWrite && (int'(cfgRow) == o)) begin
        orRow[o] <= cfgData[NumTerms-1:0];
      end
    end
    assign dataOut[o] = |(termVec & orRow[o]);
  end

endmodule

// File: rtl/pla_array.sv
module pla_array #(
  parameter int NumIn    = 4,
  parameter int NumOut   = 3,
  parameter int NumTerms = 6,
  parameter int MaxRows  = pla_pkg::maxOf(NumTerms, NumOut),
  parameter int AddrW    = (MaxRows > 1) ? $clog2(MaxRows) : 1,
  parameter int DataW    = pla_pkg::maxOf(2 * NumIn, NumTerms)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic              cfgPlane,
  input  logic [AddrW-1:0]  cfgRow,
  input  logic [DataW-1:0]  cfgData,
  input  logic [NumIn-1:0]  dataIn,
  output logic [NumOut-1:0] dataOut
);
  pla_pkg::cfgStrobe_t   strobe;
  logic [NumTerms-1:0]   termVec;

  pla_ctrl #(
    .NumTerms(NumTerms),
    .NumOut  (NumOut),
    .AddrW   (AddrW)
  ) u_ctrl (
    .cfgWe   (cfgWe),
    .cfgPlane(cfgPlane),
    .cfgRow  (cfgRow),
    .strobe  (strobe)
  );

  pla_datapath #(
    .NumIn   (NumIn),
    .NumOut  (NumOut),
    .NumTerms(NumTerms),
    .AddrW   (AddrW),
    .DataW   (DataW)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .cfgRow (cfgRow),
    .cfgData(cfgData),
    .dataIn (dataIn),
    .termVec(termVec),
    .dataOut(dataOut)
  );

endmodule

// File: rtl/pla_array_chk.sv
module pla_array_chk #(
  parameter int NumIn    = 4,
  parameter int NumOut   = 3,
  parameter int NumTerms = 6,
  parameter int AddrW    = 3
) (
  input logic                clk,
  input logic                rstN,
  input logic                cfgWe,
  input logic                cfgPlane,
  input logic [AddrW-1:0]    cfgRow,
  input logic [NumIn-1:0]    dataIn,
  input logic [NumOut-1:0]   dataOut,
  input logic [NumTerms-1:0] termVec,
  input pla_pkg::cfgStrobe_t strobe
);
  logic rowBad;
  assign rowBad = cfgPlane ? (int'(cfgRow) >= NumOut) : (int'(cfgRow) >= NumTerms);

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (dataOut == '0));

  assert_hold_no_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(cfgWe) && $stable(dataIn)) |-> $stable(dataOut));

  assert_bad_row_ignored_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && rowBad) |=> (!$stable(dataIn) || $stable(dataOut)));

  assert_out_needs_term_R5: assert property (@(posedge clk) disable iff (!rstN)
    (|dataOut) |-> (|termVec));

  assert_single_plane_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.andWrite, strobe.orWrite}));

  assert_strobe_needs_we_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.andWrite || strobe.orWrite) |-> cfgWe);

endmodule

bind pla_array pla_array_chk #(
  .NumIn   (NumIn),
  .NumOut  (NumOut),
  .NumTerms(NumTerms),
  .AddrW   (AddrW)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .cfgWe   (cfgWe),
  .cfgPlane(cfgPlane),
  .cfgRow  (cfgRow),
  .dataIn  (dataIn),
  .dataOut (dataOut),
  .termVec (termVec),
  .strobe  (strobe)
);

// File: tb/tb_pla_array.sv
`timescale 1ns/1ps
module tb_pla_array;
  localparam int NumIn    = 4;
  localparam int NumOut   = 3;
  localparam int NumTerms = 6;
  localparam int AddrW    = 3;
  localparam int DataW    = 8;
  localparam int LitW     = 2 * NumIn;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cfgWe = 1'b0;
  logic              cfgPlane = 1'b0;
  logic [AddrW-1:0]  cfgRow = '0;
  logic [DataW-1:0]  cfgData = '0;
  logic [NumIn-1:0]  dataIn = '0;
  logic [NumOut-1:0] dataOut;

  int checks = 0;
  int fails  = 0;
  bit track  = 1'b0;
  bit done   = 1'b0;

  logic [LitW-1:0]     andM [NumTerms];
  logic [NumTerms-1:0] orM  [NumOut];

  always #2 clk = ~clk;

  pla_array dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgPlane(cfgPlane),
    .cfgRow(cfgRow), .cfgData(cfgData), .dataIn(dataIn), .dataOut(dataOut)
  );

  function automatic logic [NumOut-1:0] refEval(input logic [NumIn-1:0] x);
    logic [NumTerms-1:0] terms;
    logic [NumOut-1:0]   res;
    for (int t = 0; t < NumTerms; t++) begin
      terms[t] = 1'b1;
      for (int i = 0; i < NumIn; i++) begin
        if (andM[t][2*i]   && !x[i]) terms[t] = 1'b0;
        if (andM[t][2*i+1] &&  x[i]) terms[t] = 1'b0;
      end
    end
    for (int o = 0; o < NumOut; o++) res[o] = |(orM[o] & terms);
    return res;
  endfunction

  task automatic check(input string tag, input logic [NumOut-1:0] act,
                       input logic [NumOut-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: dataIn=%b actual=%b expected=%b", tag, dataIn, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // Per-cycle comparison against the behavioural model
  always @(negedge clk) begin
    if (track) check("R10 per-cycle", dataOut, refEval(dataIn));
  end

  task automatic cfgWrite(input logic plane, input int row, input logic [DataW-1:0] data);
    @(posedge clk); #1;
    cfgWe = 1'b1; cfgPlane = plane; cfgRow = AddrW'(row); cfgData = data;
    @(posedge clk); #1;
    cfgWe = 1'b0;
    if (!plane && row < NumTerms) andM[row] = data[LitW-1:0];
    if (plane && row < NumOut)    orM[row]  = data[NumTerms-1:0];
  endtask

  task automatic applyIn(input logic [NumIn-1:0] x);
    @(posedge clk); #1;
    dataIn = x;
    @(negedge clk); #0.5;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    summary();
  end

  initial begin
    for (int t = 0; t < NumTerms; t++) andM[t] = '0;
    for (int o = 0; o < NumOut; o++)   orM[o]  = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    track = 1'b1;

    for (int x = 0; x < 16; x++) begin
      applyIn(NumIn'(x));
      check("R1 reset state", dataOut, '0);
    end

    // Empty term 0 routed to output 0 only
    cfgWrite(1'b1, 0, 8'b0000_0001);
    for (int x = 0; x < 16; x++) begin
      applyIn(NumIn'(x));
      check("R3 empty term", dataOut[0], 1'b1);
      check("R6 empty OR rows", {1'b0, dataOut[2:1]}, '0);
    end

    // Term 1 = in0 & ~in2 (bits 0 and 5)
    cfgWrite(1'b0, 1, 8'h21);
    cfgWrite(1'b1, 1, 8'b0000_0010);
    for (int x = 0; x < 16; x++) begin
      applyIn(NumIn'(x));
      check("R2 literal encoding", dataOut[1], x[0] & ~x[2]);
    end

    // Term 2 = in1 & ~in1
    cfgWrite(1'b0, 2, 8'h0C);
    cfgWrite(1'b1, 2, 8'b0000_0100);
    for (int x = 0; x < 16; x++) begin
      applyIn(NumIn'(x));
      check("R4 contradictory term", dataOut[2], 1'b0);
    end

    // Share term 1 between outputs 1 and 2
    cfgWrite(1'b1, 2, 8'b0000_0110);
    for (int x = 0; x < 16; x++) begin
      applyIn(NumIn'(x));
      check("R5 shared term", {dataOut[2], dataOut[1]}, {2{x[0] & ~x[2]}});
    end

    // Write timing: clear output 0's row
    @(posedge clk); #1;
    dataIn = 4'b0000;
    cfgWe = 1'b1; cfgPlane = 1'b1; cfgRow = 3'd0; cfgData = '0;
    @(negedge clk); #0.5;
    check("R7 before edge", dataOut[0], 1'b1);
    @(posedge clk); #1;
    cfgWe = 1'b0;
    orM[0] = '0;
    @(negedge clk); #0.5;
    check("R7 after edge", dataOut[0], 1'b0);

    // Out-of-range rows
    cfgWrite(1'b0, 6, 8'hFF);
    cfgWrite(1'b0, 7, 8'hFF);
    cfgWrite(1'b1, 3, 8'hFF);
    cfgWrite(1'b1, 7, 8'hFF);
    for (int x = 0; x < 16; x++) begin
      applyIn(NumIn'(x));
      check("R8 out-of-range write", dataOut, {{2{x[0] & ~x[2]}}, 1'b0});
    end

    // Combinational response within one cycle
    @(posedge clk); #1;
    dataIn = 4'b0001;
    #0.5 check("R9 same-cycle rise", dataOut[1], 1'b1);
    dataIn = 4'b0101;
    #0.5 check("R9 same-cycle fall", dataOut[1], 1'b0);

    for (int k = 0; k < 20; k++) begin
      for (int t = 0; t < NumTerms; t++) cfgWrite(1'b0, t, DataW'($urandom));
      for (int o = 0; o < NumOut; o++)   cfgWrite(1'b1, o, DataW'($urandom));
      for (int x = 0; x < 16; x++) begin
        applyIn(NumIn'(x));
        check("R10 random config", dataOut, refEval(NumIn'(x)));
      end
    end

    track = 1'b0;
    summary();
  end

endmodule